// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands with no clock and no state. Each result bit depends only on the two operands present at that moment. One AND gate per bit pair forms every partial product. Rows of half and full adders then fold those bits together in carry-save fashion: each cell sends its sum into its own column and its carry into the column above, and no carry travels sideways within a row. Once only a sum row and a carry row remain, a short ripple adder merges them into the upper half of the product.

Every adder cell is an explicit half-adder or full-adder instance, and the design contains no multiply operator. The operand width is a parameter with a default of 4, which gives an 8-bit product. It fits anywhere a small unsigned product is needed within a single combinational timing path.

Top module: `array_multiplier`

## Requirements
- R1: The AND of multiplicand bit i and multiplier bit j carries weight i+j: with one-hot operands 1<<i and 1<<j the product is exactly 1<<(i+j).
- R2: For every pair of W-bit unsigned operands, `product` equals their arithmetic product, held in 2W bits.
- R3: Bit 0 of the product always equals the AND of bit 0 of both operands.
- R4: If either operand is zero, the product is zero.
- R5: If one operand is 1, the product equals the other operand, zero-extended.
- R6: The largest operands give (2^W-1)^2 without loss; for W=4 that is 15*15 = 225 (8'hE1).
- R7: For W=4, 12 * 13 gives 156 (8'b1001_1100).
- R8: If the multiplier is a power of two, 1<<k, the product equals the multiplicand shifted left by k.
- R9: If the top bit of both operands is 0, the top two product bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | W | Unsigned multiplicand |
| mplier | input | W | Unsigned multiplier |
| product | output | 2W | Unsigned product of the two operands |

## Verification
The operands are applied in several distinct patterns. One-hot operand pairs isolate the column weight of each single partial product, so a cell wired into the wrong column shows up at once. Zero, one and all-ones operands probe the identity and saturation corners: all-ones drives every carry through the array and the final ripple adder. Powers of two test pure shifting, and small operands with clear top bits show whether stray carries reach the upper product bits. An exhaustive sweep of all 256 pairs, compared against a product computed in the bench, covers any remaining gap.

// File: rtl/array_multiplier.sv
module mul_half_add (
  input  logic x,
  input  logic y,
  output logic s,
  output logic co
);
  assign s  = x ^ y;
  assign co = x & y;
endmodule

module mul_full_add (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ z;
  assign co = (x & y) | (z & (x ^ y));
endmodule

module array_multiplier #(
  parameter int W = 4
) (
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] product
);
  localparam int PW = 2 * W;

  logic [W-1:0] pp [W];
  logic [W-1:0] sr [1:W-1];
  logic [W-1:0] cr [1:W-1];
  logic [W-2:0] rc;

  for (genvar j = 0; j < W; j++) begin : g_pp
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign pp[j][i] = mcand[i] & mplier[j];
    end
  end

  assign product[0] = pp[0][0];

  for (genvar j = 1; j < W; j++) begin : g_row
    for (genvar i = 0; i < W; i++) begin : g_cell
      if (j == 1 && i < W - 1) begin : g_ha_first
        mul_half_add u_ha (.x(pp[1][i]), .y(pp[0][i+1]), .s(sr[1][i]), .co(cr[1][i]));
      end else if (j == 1) begin : g_top_first
        assign sr[1][i] = pp[1][i];
        assign cr[1][i] = 1'b0;
      end else if (i < W - 1) begin : g_fa
        mul_full_add u_fa (.x(pp[j][i]), .y(sr[j-1][i+1]), .z(cr[j-1][i]),
                           .s(sr[j][i]), .co(cr[j][i]));
      end else begin : g_ha_top
        mul_half_add u_ha (.x(pp[j][i]), .y(cr[j-1][i]), .s(sr[j][i]), .co(cr[j][i]));
      end
    end
    assign product[j] = sr[j][0];
  end

  for (genvar k = 0; k < W - 1; k++) begin : g_cpa
    if (k == 0) begin : g_first
      mul_half_add u_ha (.x(sr[W-1][1]), .y(cr[W-1][0]), .s(product[W]), .co(rc[0]));
    end else begin : g_mid
      mul_full_add u_fa (.x(sr[W-1][k+1]), .y(cr[W-1][k]), .z(rc[k-1]),
                         .s(product[W+k]), .co(rc[k]));
    end
  end
  assign product[PW-1] = cr[W-1][W-1] ^ rc[W-2];

  always_comb begin
    p_lsb_r3: assert (product[0] == (mcand[0] & mplier[0]))
      else $error("R3: product lsb differs from operand lsb AND");
    if (mcand == '0 || mplier == '0)
      p_zero_r4: assert (product == '0) else $error("R4: zero operand, nonzero product");
    if (mplier == W'(1))
      p_unit_r5: assert (product == PW'(mcand)) else $error("R5: times one differs");
    if (mcand == W'(1))
      p_unit_b_r5: assert (product == PW'(mplier)) else $error("R5: one times differs");
    if (!mcand[W-1] && !mplier[W-1])
      p_no_overflow_r9: assert (product[PW-1:PW-2] == 2'b00)
        else $error("R9: small operands set top product bits");
    if ($countones(mplier) == 1)
      p_shift_r8: assert (product == (PW'(mcand) << $clog2(mplier)))
        else $error("R8: power-of-two multiplier is not a shift");
  end
endmodule

// File: tb/array_multiplier_test.sv
module array_multiplier_test;
  localparam int PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic [W-1:0] mcand, mplier;
  logic [2*W-1:0] product;
  int checks = 0, fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  array_multiplier #(.W(W)) uut (.mcand(mcand), .mplier(mplier), .product(product));

  // {multiplicand, multiplier, expected product}
  localparam logic [15:0] VEC [10] = '{
    {4'd12, 4'd13, 8'd156},  // R7
    {4'd15, 4'd15, 8'd225},  // R6
    {4'd0,  4'd9,  8'd0},    // R4
    {4'd11, 4'd0,  8'd0},    // R4
    {4'd1,  4'd7,  8'd7},    // R5
    {4'd14, 4'd1,  8'd14},   // R5
    {4'd5,  4'd8,  8'd40},   // R8
    {4'd9,  4'd4,  8'd36},   // R8
    {4'd7,  4'd7,  8'd49},   // R9
    {4'd6,  4'd5,  8'd30}    // R9
  };

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk);
    mcand  = x;
    mplier = y;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2*W-1:0] got, input logic [2*W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: %0d x %0d -> got %0d expected %0d", req, mcand, mplier, got, exp);
    end
  endtask

  initial begin
    mcand = '0;
    mplier = '0;
    @(negedge clk);
    check("R4 idle zero", product, 8'd0);

    for (int n = 0; n < 10; n++) begin
      apply(VEC[n][15:12], VEC[n][11:8]);
      check("R2 table", product, VEC[n][7:0]);
    end

    apply(4'd12, 4'd13);
    check("R7", product, 8'b1001_1100);
    apply(4'd15, 4'd15);
    check("R6", product, 8'hE1);
    apply(4'd0, 4'd15);
    check("R4", product, 8'd0);
    apply(4'd13, 4'd1);
    check("R5", product, 8'd13);
    apply(4'd3, 4'd5);
    check("R3", {7'd0, product[0]}, 8'd1);
    apply(4'd6, 4'd5);
    check("R3", {7'd0, product[0]}, 8'd0);
    apply(4'd7, 4'd6);
    check("R9", {6'd0, product[7:6]}, 8'd0);

    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++) begin
        apply(4'(1 << i), 4'(1 << j));
        check("R1 one-hot", product, 8'(1 << (i + j)));
      end

    for (int k = 0; k < W; k++) begin
      apply(4'd11, 4'(1 << k));
      check("R8 shift", product, 8'(11 << k));
    end

    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        apply(4'(x), 4'(y));
        check("R2 sweep", product, 8'(x * y));
      end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule